// File: doc/BRIEF.md
# Serial boot-loader frame checker

This block is the byte-level protocol engine for the RAM-load stage of a serial boot loader. It sits behind a UART or synchronous serial front end. It receives bytes on a valid/ready port, and each byte carries a receive-error flag. While idle it waits for a command byte. After the RAM-load command it takes in a password frame, then a header frame that gives the load address and the byte count, and it checks each frame. After each frame it returns a one-byte acknowledge on a transmit port.

Each frame is checked in a fixed priority order: first the receive errors, then an 8-bit zero-sum checksum, then, for the password frame only, the password rule. Any failure sends the engine back to waiting for a command. After a good header the block presents the load address and byte count. It then forwards exactly that many payload bytes to a RAM write port at consecutive addresses. The twelve reference password bytes come in on a flat input bus.

Top module: `boot_frame_checker`

## Requirements
- R1: While waiting for a command, every received byte is consumed. Only the byte 30h starts a password frame. Any other byte produces no acknowledge and leaves the engine waiting for a command.
- R2: The password frame is exactly 13 bytes: 12 password bytes and then one checksum byte. No acknowledge appears before the 13th byte has been accepted.
- R3: If any byte of a frame arrived with the receive-error flag set, the acknowledge is 18h. The engine then returns to waiting for a command. All bytes of the frame are still taken in before this acknowledge.
- R4: When the synchronous-mode input is high, receive-error flags are ignored.
- R5: A frame whose bytes do not sum to zero modulo 256 is acknowledged with 11h, and the engine returns to waiting for a command. A receive error takes precedence, so it gives 18h even when the sum is also wrong.
- R6: The password is compared in receive order, where byte k of the frame is checked against pwd_i[8k+7:8k]. Any mismatch gives 11h and a return to waiting for a command.
- R7: If all 12 reference bytes hold the same value and that value is not FFh, the password check fails with 11h even when every byte matches. Twelve FFh reference bytes with a matching frame pass.
- R8: A password frame that passes every check is acknowledged with 10h, and the engine then expects the header frame. The acknowledge is always one of 10h, 11h or 18h.
- R9: The header frame is 7 bytes: a 4-byte address with the most significant byte first, a 2-byte count with the high byte first, and a checksum. It follows the rules of R3 to R5. When it passes, the acknowledge is 10h, and load_addr_o, byte_cnt_o and hdr_valid_o = 1 are presented once that acknowledge has been accepted.
- R10: After a good header, exactly byte_cnt_o payload bytes are written, one write per accepted byte, to load_addr_o, load_addr_o+1, and so on. The engine then returns to waiting for a command. A count of zero returns there at once.
- R11: An acknowledge stays on tx_data_o with tx_valid_o high, unchanged, until tx_ready_i is seen. rx_ready_o is low while it is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sync_mode_i | input | 1 | Serial port in synchronous mode; receive errors are ignored |
| pwd_i | input | 96 | Reference password, byte k at bits 8k+7:8k |
| rx_valid_i | input | 1 | Received byte valid |
| rx_data_i | input | 8 | Received byte |
| rx_err_i | input | 1 | Receive error on this byte |
| rx_ready_o | output | 1 | Engine can take a byte |
| tx_valid_o | output | 1 | Acknowledge byte pending |
| tx_data_o | output | 8 | Acknowledge code |
| tx_ready_i | input | 1 | Serial side takes the acknowledge |
| hdr_valid_o | output | 1 | A good header has been accepted since the last command |
| load_addr_o | output | 32 | RAM start address from the header |
| byte_cnt_o | output | 16 | Payload byte count from the header |
| mem_we_o | output | 1 | RAM write strobe |
| mem_addr_o | output | 32 | RAM write address |
| mem_data_o | output | 8 | RAM write data |

## Verification
The hardest outcomes to reach are those where only the lowest-priority check can decide. One example is twelve equal reference bytes that are not FFh, matched exactly and sent with a correct checksum. Another is a lone receive error on the checksum byte of a frame that is otherwise perfect. The stimulus reaches these cases by building each frame in the bench and recomputing its checksum after any change to its contents. Some errors are injected deliberately, and the header is reached only after a password that has been driven to pass. A seeded random loop then mixes mutated bytes, corrupted sums, flagged bytes and the synchronous mode across both frames.

// File: rtl/boot_pkg.sv
package boot_pkg;
  typedef enum logic [2:0] {
    ST_CMD, ST_PWD, ST_PWD_ACK, ST_HDR, ST_HDR_ACK, ST_PAY
  } boot_st_e;

  localparam logic [7:0] ACK_OK    = 8'h10;
  localparam logic [7:0] ACK_BAD   = 8'h11;
  localparam logic [7:0] ACK_RXERR = 8'h18;
endpackage

// File: rtl/boot_frame_acc.sv
// Running modulo-256 sum and sticky receive-error flag for one frame
module boot_frame_acc (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       take_i,
  input  logic       sync_mode_i,
  input  logic [7:0] data_i,
  input  logic       err_i,
  output logic [7:0] sum_nxt_o,
  output logic       err_nxt_o
);
  logic [7:0] sum_q;
  logic       err_q;

  assign sum_nxt_o = sum_q + data_i;
  assign err_nxt_o = err_q | (err_i & ~sync_mode_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sum_q <= '0;
      err_q <= 1'b0;
    end else if (clr_i) begin
      sum_q <= '0;
      err_q <= 1'b0;
    end else if (take_i) begin
      sum_q <= sum_nxt_o;
      err_q <= err_nxt_o;
    end
  end
endmodule

// File: rtl/boot_pwd_check.sv
module boot_pwd_check #(
  parameter int unsigned N_BYTES = 12
) (
  input  logic [8*N_BYTES-1:0] rx_i,
  input  logic [8*N_BYTES-1:0] ref_i,
  output logic                 bad_o
);
  logic [N_BYTES-1:0] mism;
  logic [N_BYTES-1:0] same;

  for (genvar k = 0; k < N_BYTES; k++) begin : g_byte
    assign mism[k] = rx_i[8*k +: 8] != ref_i[8*k +: 8];
    assign same[k] = ref_i[8*k +: 8] == ref_i[7:0];
  end

  // uniform non-erased reference is rejected regardless of the comparison
  assign bad_o = (|mism) | ((&same) & (ref_i[7:0] != 8'hFF));
endmodule

// File: rtl/boot_frame_checker.sv
module boot_frame_checker
  import boot_pkg::*;
#(
  parameter int unsigned PWD_BYTES  = 12,
  parameter int unsigned ADDR_BYTES = 4,
  parameter int unsigned CNT_BYTES  = 2,
  parameter logic [7:0]  CMD_BYTE   = 8'h30
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    sync_mode_i,
  input  logic [8*PWD_BYTES-1:0]  pwd_i,
  input  logic                    rx_valid_i,
  input  logic [7:0]              rx_data_i,
  input  logic                    rx_err_i,
  output logic                    rx_ready_o,
  output logic                    tx_valid_o,
  output logic [7:0]              tx_data_o,
  input  logic                    tx_ready_i,
  output logic                    hdr_valid_o,
  output logic [8*ADDR_BYTES-1:0] load_addr_o,
  output logic [8*CNT_BYTES-1:0]  byte_cnt_o,
  output logic                    mem_we_o,
  output logic [8*ADDR_BYTES-1:0] mem_addr_o,
  output logic [7:0]              mem_data_o
);
  localparam int unsigned HDR_BYTES = ADDR_BYTES + CNT_BYTES;
  localparam int unsigned ADDR_W    = 8 * ADDR_BYTES;
  localparam int unsigned CNT_W     = 8 * CNT_BYTES;
  localparam int unsigned MAX_BYTES = (PWD_BYTES > HDR_BYTES) ? PWD_BYTES : HDR_BYTES;
  localparam int unsigned IDX_W     = $clog2(MAX_BYTES + 1);

  boot_st_e               st_q;
  logic [IDX_W-1:0]       idx_q;
  logic [8*PWD_BYTES-1:0] pwd_rx_q;
  logic [8*HDR_BYTES-1:0] hdr_q;
  logic [ADDR_W-1:0]      ptr_q;
  logic [CNT_W-1:0]       rem_q;
  logic                   hdr_ok_q;

  logic       rx_fire, in_frame, last, frm_clr, pwd_bad, err_nxt;
  logic [7:0] sum_nxt, code;

  assign rx_ready_o = (st_q == ST_CMD) || (st_q == ST_PWD) ||
                      (st_q == ST_HDR) || (st_q == ST_PAY);
  assign rx_fire    = rx_valid_i & rx_ready_o;
  assign in_frame   = (st_q == ST_PWD) || (st_q == ST_HDR);
  assign last       = ((st_q == ST_PWD) && (idx_q == IDX_W'(PWD_BYTES))) ||
                      ((st_q == ST_HDR) && (idx_q == IDX_W'(HDR_BYTES)));
  assign frm_clr    = !in_frame;

  boot_frame_acc i_acc (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (frm_clr),
    .take_i      (rx_fire & in_frame),
    .sync_mode_i (sync_mode_i),
    .data_i      (rx_data_i),
    .err_i       (rx_err_i),
    .sum_nxt_o   (sum_nxt),
    .err_nxt_o   (err_nxt)
  );

  boot_pwd_check #(.N_BYTES(PWD_BYTES)) i_pwd (
    .rx_i  (pwd_rx_q),
    .ref_i (pwd_i),
    .bad_o (pwd_bad)
  );

  // priority: receive error, checksum, password
  always_comb begin
    if (err_nxt)                          code = ACK_RXERR;
    else if (sum_nxt != 8'h00)            code = ACK_BAD;
    else if ((st_q == ST_PWD) && pwd_bad) code = ACK_BAD;
    else                                  code = ACK_OK;
  end

  assign hdr_valid_o = hdr_ok_q;
  assign load_addr_o = hdr_q[8*HDR_BYTES-1 -: ADDR_W];
  assign byte_cnt_o  = hdr_q[CNT_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_CMD;
      idx_q      <= '0;
      pwd_rx_q   <= '0;
      hdr_q      <= '0;
      ptr_q      <= '0;
      rem_q      <= '0;
      hdr_ok_q   <= 1'b0;
      tx_valid_o <= 1'b0;
      tx_data_o  <= '0;
      mem_we_o   <= 1'b0;
      mem_addr_o <= '0;
      mem_data_o <= '0;
    end else begin
      mem_we_o <= 1'b0;
      unique case (st_q)
        ST_CMD: begin
          idx_q <= '0;
          if (rx_fire && rx_data_i == CMD_BYTE) begin
            st_q     <= ST_PWD;
            hdr_ok_q <= 1'b0;
          end
        end
        ST_PWD, ST_HDR: begin
          if (rx_fire) begin
            if (last) begin
              tx_valid_o <= 1'b1;
              tx_data_o  <= code;
              idx_q      <= '0;
              st_q       <= (st_q == ST_PWD) ? ST_PWD_ACK : ST_HDR_ACK;
            end else begin
              idx_q <= idx_q + 1'b1;
              if (st_q == ST_PWD) pwd_rx_q[8*int'(idx_q) +: 8] <= rx_data_i;
              else                hdr_q <= {hdr_q[8*HDR_BYTES-9:0], rx_data_i};
            end
          end
        end
        ST_PWD_ACK: begin
          if (tx_ready_i) begin
            tx_valid_o <= 1'b0;
            st_q       <= (tx_data_o == ACK_OK) ? ST_HDR : ST_CMD;
          end
        end
        ST_HDR_ACK: begin
          if (tx_ready_i) begin
            tx_valid_o <= 1'b0;
            if (tx_data_o == ACK_OK) begin
              hdr_ok_q <= 1'b1;
              ptr_q    <= load_addr_o;
              rem_q    <= byte_cnt_o;
              st_q     <= (byte_cnt_o == '0) ? ST_CMD : ST_PAY;
            end else begin
              st_q <= ST_CMD;
            end
          end
        end
        ST_PAY: begin
          if (rx_fire) begin
            mem_we_o   <= 1'b1;
            mem_addr_o <= ptr_q;
            mem_data_o <= rx_data_i;
            ptr_q      <= ptr_q + 1'b1;
            rem_q      <= rem_q - 1'b1;
            if (rem_q == CNT_W'(1)) st_q <= ST_CMD;
          end
        end
        default: st_q <= ST_CMD;
      endcase
    end
  end
endmodule

// File: rtl/boot_frame_checker_sva.sv
module boot_frame_checker_sva #(
  parameter int unsigned ADDR_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rx_ready_o,
  input logic              tx_valid_o,
  input logic [7:0]        tx_data_o,
  input logic              tx_ready_i,
  input logic              hdr_valid_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o
);
  AST_ACK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o && !tx_ready_i |=> tx_valid_o && $stable(tx_data_o)); // R11

  AST_RX_BLOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o |-> !rx_ready_o); // R11

  AST_ACK_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o |-> (tx_data_o == 8'h10 || tx_data_o == 8'h11 || tx_data_o == 8'h18)); // R8

  AST_WR_AFTER_HDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> hdr_valid_o); // R9

  AST_WR_SEQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o && $past(mem_we_o) |-> mem_addr_o == $past(mem_addr_o) + 1'b1); // R10

  AST_NO_WR_IN_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o |-> !mem_we_o); // R10
endmodule

bind boot_frame_checker boot_frame_checker_sva #(.ADDR_W(8*ADDR_BYTES)) i_sva (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .rx_ready_o  (rx_ready_o),
  .tx_valid_o  (tx_valid_o),
  .tx_data_o   (tx_data_o),
  .tx_ready_i  (tx_ready_i),
  .hdr_valid_o (hdr_valid_o),
  .mem_we_o    (mem_we_o),
  .mem_addr_o  (mem_addr_o)
);

// File: tb/test_boot_frame_checker.sv
module test_boot_frame_checker;
  localparam logic [7:0] CMD = 8'h30;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sync_mode = 1'b0;
  logic [95:0] pwd;
  logic        rx_valid = 1'b0, rx_err = 1'b0, tx_ready = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        rx_ready, tx_valid, hdr_valid, mem_we;
  logic [7:0]  tx_data, mem_data;
  logic [31:0] load_addr, mem_addr;
  logic [15:0] byte_cnt;

  always #4 clk = ~clk;

  boot_frame_checker i_boot_frame_checker (
    .clk_i(clk), .rst_ni(rst_n), .sync_mode_i(sync_mode), .pwd_i(pwd),
    .rx_valid_i(rx_valid), .rx_data_i(rx_data), .rx_err_i(rx_err), .rx_ready_o(rx_ready),
    .tx_valid_o(tx_valid), .tx_data_o(tx_data), .tx_ready_i(tx_ready),
    .hdr_valid_o(hdr_valid), .load_addr_o(load_addr), .byte_cnt_o(byte_cnt),
    .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_data_o(mem_data)
  );

  int n_chk = 0, n_fail = 0;
  logic [7:0]  st [0:11];
  logic [7:0]  fb [0:12];
  bit          fe [0:12];
  logic [7:0]  pl [0:63];
  logic [31:0] wr_addr [0:63];
  logic [7:0]  wr_data [0:63];
  int          wr_n = 0;

  always_comb for (int k = 0; k < 12; k++) pwd[8*k +: 8] = st[k];

  always @(negedge clk) if (mem_we && wr_n < 64) begin
    wr_addr[wr_n] = mem_addr;
    wr_data[wr_n] = mem_data;
    wr_n++;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] d, input bit e);
    while (!rx_ready) @(negedge clk);
    rx_valid = 1'b1; rx_data = d; rx_err = e;
    @(negedge clk);
    rx_valid = 1'b0; rx_err = 1'b0;
  endtask

  task automatic send_frame(input int n);
    for (int i = 0; i < n; i++) send_byte(fb[i], fe[i]);
  endtask

  task automatic get_ack(input logic [7:0] exp, input string req, input int hold);
    int t = 0;
    logic [7:0] d0;
    while (!tx_valid && t < 50) begin @(negedge clk); t++; end
    check(req, {31'd0, tx_valid}, 32'd1);
    if (hold > 0) begin
      d0 = tx_data;
      repeat (hold) @(negedge clk);
      check("R11", {22'd0, tx_valid, rx_ready, tx_data}, {22'd0, 1'b1, 1'b0, d0});
    end
    tx_ready = 1'b1;
    check(req, {24'd0, tx_data}, {24'd0, exp});
    @(negedge clk);
    tx_ready = 1'b0;
  endtask

  function automatic void fill_sum(input int n);
    logic [7:0] s = '0;
    for (int i = 0; i < n - 1; i++) s += fb[i];
    fb[n-1] = 8'h00 - s;
  endfunction

  function automatic bit pwd_bad();
    bit mis = 0, same = 1;
    for (int i = 0; i < 12; i++) begin
      mis  |= (fb[i] != st[i]);
      same &= (st[i] == st[0]);
    end
    return mis || (same && st[0] != 8'hFF);
  endfunction

  function automatic logic [7:0] exp_code(input int n, input bit is_pwd);
    logic [7:0] s = '0;
    bit e = 0;
    for (int i = 0; i < n; i++) begin s += fb[i]; e |= fe[i]; end
    if (e && !sync_mode) return 8'h18;
    if (s != 8'h00) return 8'h11;
    if (is_pwd && pwd_bad()) return 8'h11;
    return 8'h10;
  endfunction

  function automatic void mk_pwd();
    for (int i = 0; i < 12; i++) fb[i] = st[i];
    for (int i = 0; i < 13; i++) fe[i] = 1'b0;
    fill_sum(13);
  endfunction

  function automatic void mk_hdr(input logic [31:0] a, input logic [15:0] c);
    fb[0] = a[31:24]; fb[1] = a[23:16]; fb[2] = a[15:8]; fb[3] = a[7:0];
    fb[4] = c[15:8];  fb[5] = c[7:0];
    for (int i = 0; i < 13; i++) fe[i] = 1'b0;
    fill_sum(7);
  endfunction

  task automatic payload(input logic [31:0] a, input int c);
    wr_n = 0;
    for (int i = 0; i < c; i++) begin
      pl[i] = 8'($urandom);
      send_byte(pl[i], 1'b0);
    end
    repeat (2) @(negedge clk);
    check("R10 count", wr_n, c);
    for (int i = 0; i < c && i < wr_n; i++) begin
      check("R10 addr", wr_addr[i], a + i);
      check("R10 data", {24'd0, wr_data[i]}, {24'd0, pl[i]});
    end
  endtask

  task automatic run_pass(input logic [31:0] a, input logic [15:0] c, input int hold);
    mk_pwd();
    send_byte(CMD, 1'b0);
    send_frame(13);
    get_ack(8'h10, "R8 pwd ok", hold);
    mk_hdr(a, c);
    send_frame(7);
    get_ack(8'h10, "R9 hdr ok", 0);
    check("R9 addr", load_addr, a);
    check("R9 cnt", {16'd0, byte_cnt}, {16'd0, c});
    check("R9 valid", {31'd0, hdr_valid}, 32'd1);
    payload(a, int'(c));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    logic [7:0] ex;
    logic [31:0] a;
    int c;
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 12; i++) st[i] = 8'($urandom);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset", {28'd0, rx_ready, tx_valid, hdr_valid, mem_we}, {28'd0, 4'b1000});

    // R1: non-command byte is swallowed
    send_byte(8'h31, 1'b0);
    repeat (4) @(negedge clk);
    check("R1 junk", {30'd0, tx_valid, rx_ready}, {30'd0, 2'b01});

    // R11 held ack, full pass
    run_pass(32'h1234_5678, 16'd5, 3);

    // R2: no ack after 12 bytes
    mk_pwd();
    send_byte(CMD, 1'b0);
    send_frame(12);
    repeat (3) @(negedge clk);
    check("R2 early", {31'd0, tx_valid}, 32'd0);
    send_byte(fb[12], 1'b0);
    get_ack(8'h10, "R2 len", 0);
    mk_hdr(32'h0, 16'd0); fb[6] = fb[6] ^ 8'h01;
    send_frame(7);
    get_ack(8'h11, "R5 hdr sum", 0);

    // R3 + R5 priority
    mk_pwd(); fe[4] = 1'b1; fb[12] = fb[12] + 8'd3;
    send_byte(CMD, 1'b0); send_frame(13);
    get_ack(8'h18, "R3 prio", 0);
    mk_pwd(); fe[12] = 1'b1;
    send_byte(CMD, 1'b0); send_frame(13);
    get_ack(8'h18, "R3 last byte", 0);

    // R4
    sync_mode = 1'b1;
    mk_pwd(); fe[7] = 1'b1;
    send_byte(CMD, 1'b0); send_frame(13);
    get_ack(8'h10, "R4 sync", 0);
    mk_hdr(32'hA0, 16'd1); fe[2] = 1'b1; fb[6] = fb[6] + 8'd1;
    send_frame(7);
    get_ack(8'h11, "R4 hdr sync sum", 0);
    sync_mode = 1'b0;

    // R5 pwd checksum, R6 mismatch
    mk_pwd(); fb[12] = fb[12] ^ 8'h80;
    send_byte(CMD, 1'b0); send_frame(13);
    get_ack(8'h11, "R5 pwd sum", 0);
    mk_pwd(); fb[3] = fb[3] + 8'd1; fb[5] = fb[5] - 8'd1;
    send_byte(CMD, 1'b0); send_frame(13);
    get_ack(8'h11, "R6 mismatch", 0);

    // R7 uniform reference
    for (int i = 0; i < 12; i++) st[i] = 8'h5A;
    mk_pwd();
    send_byte(CMD, 1'b0); send_frame(13);
    get_ack(8'h11, "R7 uniform", 0);
    for (int i = 0; i < 12; i++) st[i] = 8'hFF;
    mk_pwd();
    send_byte(CMD, 1'b0); send_frame(13);
    get_ack(8'h10, "R7 erased", 0);
    mk_hdr(32'h10, 16'd2); fe[0] = 1'b1;
    send_frame(7);
    get_ack(8'h18, "R9 hdr rxerr", 0);

    // R10 zero count, then a normal load proves command wait
    for (int i = 0; i < 12; i++) st[i] = 8'($urandom);
    run_pass(32'hFFFF_FFFE, 16'd0, 0);
    run_pass(32'hFFFF_FFFE, 16'd4, 0);

    // random mix
    for (int it = 0; it < 30; it++) begin
      if ($urandom_range(0, 4) == 0) begin
        logic [7:0] v = ($urandom_range(0, 1) == 1) ? 8'hFF : 8'($urandom);
        for (int i = 0; i < 12; i++) st[i] = v;
      end else begin
        for (int i = 0; i < 12; i++) st[i] = 8'($urandom);
      end
      sync_mode = ($urandom_range(0, 3) == 0);
      mk_pwd();
      if ($urandom_range(0, 3) == 0) begin
        fb[$urandom_range(0, 11)] ^= 8'(1 + $urandom_range(0, 254));
        fill_sum(13);
      end
      if ($urandom_range(0, 4) == 0) fb[12] += 8'(1 + $urandom_range(0, 254));
      if ($urandom_range(0, 4) == 0) fe[$urandom_range(0, 12)] = 1'b1;
      ex = exp_code(13, 1'b1);
      send_byte(CMD, 1'b0); send_frame(13);
      get_ack(ex, ex == 8'h18 ? "R3 rnd" : (ex == 8'h11 ? "R5 R6 R7 rnd" : "R8 rnd"), $urandom_range(0, 2));
      if (ex == 8'h10) begin
        a = $urandom;
        c = $urandom_range(0, 6);
        mk_hdr(a, 16'(c));
        if ($urandom_range(0, 5) == 0) fb[6] += 8'd7;
        if ($urandom_range(0, 5) == 0) fe[$urandom_range(0, 6)] = 1'b1;
        ex = exp_code(7, 1'b0);
        send_frame(7);
        get_ack(ex, "R9 rnd", 0);
        if (ex == 8'h10) begin
          check("R9 rnd addr", load_addr, a);
          payload(a, c);
        end
      end
      sync_mode = 1'b0;
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule